// File: doc/BRIEF.md
# Fuzzy-Invalidate L1 Tag Controller

This block is the tag side of a private, set-associative L1 cache that can drop a whole class of lines in a single cycle. Besides its tag and valid bit, every resident line keeps two flags. The reuse flag records whether the line has been hit since it was filled. The fuzzy flag records that the directory supplied the line with a fuzzy marking. When a fill pushes out a valid line that was never hit after its fill, the controller may send the evicted line address to the directory as a fuzzy candidate. A free-running random source decides, and a candidate is reported on about one eviction in four.

The directory later returns such lines with the fuzzy marking set. When it serves a write to a fuzzy line, it raises a one-cycle broadcast pulse. On that pulse every valid fuzzy line in the cache is invalidated in the same cycle, and every other line is left untouched.

Lookups, fills and the broadcast pulse can all arrive in the same cycle. All three act on the state held before the clock edge. A fill always lands, even when a broadcast arrives with it. Data storage, the directory and the coherence state machine are outside this block.

Top module: `fuzzy_inv_ctrl`

## Requirements
- R1: After reset every line is invalid, `rsp_valid`, `hit` and `note_valid` are low, and any lookup misses.
- R2: A lookup (`acc_valid` high at a clock edge) raises `rsp_valid` for the following cycle. `hit` reports whether a valid line with that tag is resident in the selected set. The address splits into a byte offset (low log2(LINE_BYTES) bits, ignored), a set index (next log2(SETS) bits) and a tag (upper bits).
- R3: A fill of a tag that is already resident in its set rewrites that way and evicts nothing. Otherwise the fill takes the lowest-numbered invalid way. If no way is invalid, it takes the way named by the set's replacement pointer. After any hit or fill to way w, the pointer names way (w+1) mod WAYS. `hit_way` gives the hitting way number.
- R4: A fill clears the line's reuse flag and any later hit sets it. Evicting a line whose reuse flag is set never produces a notification.
- R5: `note_valid` rises only in the cycle after a fill that evicts a valid line whose reuse flag is clear. `note_addr` then carries the evicted line's tag and set with a zero offset.
- R6: Among such candidate evictions, the report is sent when the two low bits of a free-running 16-bit LFSR are both zero, so about 25% of candidates are reported.
- R7: A fill with `fill_fuzzy` high sets the line's fuzzy flag, and a fill with it low clears the flag. This includes a refill of a resident line.
- R8: One cycle of `flash_inv` invalidates every valid line whose fuzzy flag is set. Lines without the flag keep hitting.
- R9: When a fill and `flash_inv` occur in the same cycle, the filled line is valid afterwards, even with `fill_fuzzy` high.
- R10: A lookup in the same cycle as `flash_inv` sees the state before the edge. A fuzzy line therefore still reports a hit, and the same lookup one cycle later misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Lookup request this cycle |
| acc_addr | input | ADDR_W | Lookup byte address |
| fill_valid | input | 1 | Fill request this cycle |
| fill_addr | input | ADDR_W | Byte address of the line being filled |
| fill_fuzzy | input | 1 | Directory marked the incoming line fuzzy |
| flash_inv | input | 1 | Broadcast pulse: drop all fuzzy lines |
| rsp_valid | output | 1 | Lookup result valid (one cycle after request) |
| hit | output | 1 | Lookup found a valid matching line |
| hit_way | output | log2(WAYS) | Way that hit |
| note_valid | output | 1 | Fuzzy-candidate report to the directory |
| note_addr | output | ADDR_W | Line address of the reported eviction |

## Verification
The hardest case to reach from the ports is a candidate eviction. It needs a full set whose replacement pointer lands on a line that was never hit. Its report is also gated by a random draw that the bench cannot see. The bench keeps its own model of tags, flags and pointers, so it knows exactly which fills are candidates. It streams over a thousand fills with no intervening hits to measure the report rate. It also runs a fill-fill-hit-hit-fill pattern that forces reused victims, where no report is allowed. The same-cycle collisions (fill with broadcast, lookup with broadcast, lookup with fill) are driven both directly and inside a long pseudo-random mixed stream.

// File: rtl/fic_pkg.sv
package fic_pkg;

    // per-line state kept beside each tag
    typedef struct packed {
        logic valid;
        logic reuse;
        logic fuzzy;
    } fic_line_t;

    localparam int          RND_W    = 16;
    localparam logic [15:0] RND_TAPS = 16'hB400;

    // one Galois step, maximal length for a nonzero seed
    function automatic logic [RND_W-1:0] rnd_next(input logic [RND_W-1:0] s);
        return s[0] ? ((s >> 1) ^ RND_TAPS) : (s >> 1);
    endfunction

endpackage

// File: rtl/fic_lfsr.sv
module fic_lfsr
    import fic_pkg::*;
#(
    parameter logic [RND_W-1:0] SEED = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [RND_W-1:0] state_o
);

    logic [RND_W-1:0] state_d, state_q;

    always_comb begin
        state_d = rnd_next(state_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEED;
        else        state_q <= state_d;
    end

    assign state_o = state_q;

endmodule

// File: rtl/fic_way_match.sv
module fic_way_match #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 19,
    parameter int WAY_W = 1
) (
    input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
    input  logic [WAYS-1:0]            valid_i,
    input  logic [TAG_W-1:0]           tag_i,
    output logic                       hit_o,
    output logic [WAY_W-1:0]           way_o
);

    logic [WAYS-1:0] eq;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign eq[g] = valid_i[g] && (tags_i[g] == tag_i);
    end

    always_comb begin
        hit_o = |eq;
        way_o = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (eq[w]) way_o = WAY_W'(w);
        end
    end

endmodule

// File: rtl/fic_victim_pick.sv
module fic_victim_pick #(
    parameter int WAYS  = 2,
    parameter int WAY_W = 1
) (
    input  logic [WAYS-1:0]  valid_i,
    input  logic [WAY_W-1:0] ptr_i,
    output logic [WAY_W-1:0] way_o
);

    // lowest empty way first, otherwise the replacement pointer
    always_comb begin
        way_o = ptr_i;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_i[w]) way_o = WAY_W'(w);
        end
    end

endmodule

// File: rtl/fuzzy_inv_ctrl.sv
module fuzzy_inv_ctrl
    import fic_pkg::*;
#(
    parameter int               CACHE_BYTES = 16384,
    parameter int               LINE_BYTES  = 32,
    parameter int               WAYS        = 2,
    parameter int               ADDR_W      = 32,
    parameter logic [RND_W-1:0] RND_SEED    = 16'hACE1
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     acc_valid,
    input  logic [ADDR_W-1:0]                        acc_addr,
    input  logic                                     fill_valid,
    input  logic [ADDR_W-1:0]                        fill_addr,
    input  logic                                     fill_fuzzy,
    input  logic                                     flash_inv,
    output logic                                     rsp_valid,
    output logic                                     hit,
    output logic [((WAYS > 1) ? $clog2(WAYS) : 1)-1:0] hit_way,
    output logic                                     note_valid,
    output logic [ADDR_W-1:0]                        note_addr
);

    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int SETS  = CACHE_BYTES / (LINE_BYTES * WAYS);
    localparam int SET_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - SET_W - OFF_W;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag;
        fic_line_t [SETS-1:0][WAYS-1:0]       flg;
        logic [SETS-1:0][WAY_W-1:0]           ptr;
        logic                                 rsp;
        logic                                 hit;
        logic [WAY_W-1:0]                     hit_way;
        logic                                 note;
        logic [TAG_W-1:0]                     note_tag;
        logic [SET_W-1:0]                     note_set;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    logic [SET_W-1:0] acc_set, fill_set;
    logic [TAG_W-1:0] acc_tag, fill_tag;
    logic [WAYS-1:0]  acc_vld, fill_vld;
    logic             acc_match, fill_match;
    logic [WAY_W-1:0] acc_way, fill_way, vict_way;
    logic [RND_W-1:0] rnd_q;

    logic unused_bits;
    assign unused_bits = ^{acc_addr[OFF_W-1:0], fill_addr[OFF_W-1:0], rnd_q[RND_W-1:2]};

    function automatic logic [WAY_W-1:0] next_way(input logic [WAY_W-1:0] w);
        return (32'(w) == WAYS - 1) ? '0 : w + 1'b1;
    endfunction

    // address split
    assign acc_set  = acc_addr[OFF_W +: SET_W];
    assign acc_tag  = acc_addr[ADDR_W-1 -: TAG_W];
    assign fill_set = fill_addr[OFF_W +: SET_W];
    assign fill_tag = fill_addr[ADDR_W-1 -: TAG_W];

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            acc_vld[w]  = st_q.flg[acc_set][w].valid;
            fill_vld[w] = st_q.flg[fill_set][w].valid;
        end
    end

    fic_lfsr #(.SEED(RND_SEED)) u_rnd (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_o (rnd_q)
    );

    fic_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_acc_match (
        .tags_i  (st_q.tag[acc_set]),
        .valid_i (acc_vld),
        .tag_i   (acc_tag),
        .hit_o   (acc_match),
        .way_o   (acc_way)
    );

    fic_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_fill_match (
        .tags_i  (st_q.tag[fill_set]),
        .valid_i (fill_vld),
        .tag_i   (fill_tag),
        .hit_o   (fill_match),
        .way_o   (fill_way)
    );

    fic_victim_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
        .valid_i (fill_vld),
        .ptr_i   (st_q.ptr[fill_set]),
        .way_o   (vict_way)
    );

    always_comb begin
        logic [WAY_W-1:0] tgt;
        fic_line_t        old_line;

        st_d          = st_q;
        st_d.rsp      = acc_valid;
        st_d.hit      = 1'b0;
        st_d.hit_way  = '0;
        st_d.note     = 1'b0;
        st_d.note_tag = '0;
        st_d.note_set = '0;

        tgt      = fill_match ? fill_way : vict_way;
        old_line = st_q.flg[fill_set][tgt];

        // lookup: mark reuse and move the pointer
        if (acc_valid && acc_match) begin
            st_d.hit                          = 1'b1;
            st_d.hit_way                      = acc_way;
            st_d.flg[acc_set][acc_way].reuse  = 1'b1;
            st_d.ptr[acc_set]                 = next_way(acc_way);
        end

        // broadcast: drop every valid fuzzy line at once
        if (flash_inv) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (st_q.flg[s][w].valid && st_q.flg[s][w].fuzzy) begin
                        st_d.flg[s][w] = '0;
                    end
                end
            end
        end

        // fill last, so it overrides both of the above
        if (fill_valid) begin
            if (!fill_match && old_line.valid && !old_line.reuse && (rnd_q[1:0] == 2'b00)) begin
                st_d.note     = 1'b1;
                st_d.note_tag = st_q.tag[fill_set][tgt];
                st_d.note_set = fill_set;
            end
            st_d.tag[fill_set][tgt] = fill_tag;
            st_d.flg[fill_set][tgt] = fic_line_t'{valid: 1'b1, reuse: 1'b0, fuzzy: fill_fuzzy};
            st_d.ptr[fill_set]      = next_way(tgt);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid  = st_q.rsp;
    assign hit        = st_q.hit;
    assign hit_way    = st_q.hit_way;
    assign note_valid = st_q.note;
    assign note_addr  = {st_q.note_tag, st_q.note_set, {OFF_W{1'b0}}};

endmodule

// File: rtl/fic_chk.sv
module fic_chk
    import fic_pkg::*;
#(
    parameter int SETS = 256,
    parameter int WAYS = 2
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            acc_valid,
    input logic                            fill_valid,
    input logic                            flash_inv,
    input logic                            rsp_valid,
    input logic                            hit,
    input logic                            note_valid,
    input logic [1:0]                      rnd_lo,
    input fic_line_t [SETS-1:0][WAYS-1:0]  flg_i
);

    logic fuzzy_live;

    always_comb begin
        fuzzy_live = 1'b0;
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                if (flg_i[s][w].valid && flg_i[s][w].fuzzy) fuzzy_live = 1'b1;
            end
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!rsp_valid && !hit && !note_valid));

    // R2
    hit_needs_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(acc_valid));

    // R5
    note_needs_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        note_valid |-> $past(fill_valid));

    // R6
    note_dice_chk: assert property (@(posedge clk) disable iff (!rst_n)
        note_valid |-> ($past(rnd_lo) == 2'b00));

    // R8
    flash_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_inv && !fill_valid) |=> !fuzzy_live);

endmodule

bind fuzzy_inv_ctrl fic_chk #(.SETS(SETS), .WAYS(WAYS)) u_fic_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .fill_valid (fill_valid),
    .flash_inv  (flash_inv),
    .rsp_valid  (rsp_valid),
    .hit        (hit),
    .note_valid (note_valid),
    .rnd_lo     (rnd_q[1:0]),
    .flg_i      (st_q.flg)
);

// File: tb/tb_fuzzy_inv_ctrl.sv
`timescale 1ns/1ps
module tb_fuzzy_inv_ctrl;

    localparam int CB = 256, LB = 32, NW = 2, AW = 12, NS = 4;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          acc_valid = 0, fill_valid = 0, fill_fuzzy = 0, flash_inv = 0;
    logic [AW-1:0] acc_addr = '0, fill_addr = '0;
    logic          rsp_valid, hit, note_valid;
    logic [0:0]    hit_way;
    logic [AW-1:0] note_addr;

    always #2 clk = ~clk;

    fuzzy_inv_ctrl #(.CACHE_BYTES(CB), .LINE_BYTES(LB), .WAYS(NW), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_fuzzy(fill_fuzzy),
        .flash_inv(flash_inv), .rsp_valid(rsp_valid), .hit(hit), .hit_way(hit_way),
        .note_valid(note_valid), .note_addr(note_addr)
    );

    // reference model
    bit       mv[NS][NW], mr[NS][NW], mf[NS][NW];
    bit [4:0] mt[NS][NW];
    int       mp[NS];

    int checks = 0, errors = 0, cands = 0, notes = 0, cyc = 0;
    bit done = 0;
    int unsigned seed = 32'h1234_5678;

    function automatic int rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return int'(seed[30:16]);
    endfunction

    function automatic logic [AW-1:0] mk(int s, int t, int off);
        return {t[4:0], s[1:0], off[4:0]};
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!done && cyc > 60000) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 60000);
            summary();
            $finish;
        end
    end

    // one cycle: drive at negedge, check at next negedge, then advance model
    task automatic step(bit a, logic [AW-1:0] aa, bit f, logic [AW-1:0] fa,
                        bit fz, bit fl, string lbl);
        int as, at, fs, ft, eway, fw, vw;
        bit ehit, fm, cand;
        logic [AW-1:0] caddr;
        as = int'(aa[6:5]); at = int'(aa[11:7]);
        fs = int'(fa[6:5]); ft = int'(fa[11:7]);
        ehit = 0; eway = 0; fm = 0; fw = 0;
        for (int w = NW - 1; w >= 0; w--) begin
            if (mv[as][w] && mt[as][w] == at[4:0]) begin ehit = 1; eway = w; end
            if (mv[fs][w] && mt[fs][w] == ft[4:0]) begin fm = 1; fw = w; end
        end
        vw = mp[fs];
        for (int w = NW - 1; w >= 0; w--) if (!mv[fs][w]) vw = w;
        if (fm) vw = fw;
        cand  = f && !fm && mv[fs][vw] && !mr[fs][vw];
        caddr = mk(fs, int'(mt[fs][vw]), 0);

        acc_valid = a; acc_addr = aa; fill_valid = f; fill_addr = fa;
        fill_fuzzy = fz; flash_inv = fl;
        @(posedge clk);
        @(negedge clk);
        acc_valid = 0; fill_valid = 0; fill_fuzzy = 0; flash_inv = 0;

        check(rsp_valid == a, "R2", int'(rsp_valid), int'(a));
        if (a) begin
            check(hit == ehit, lbl, int'(hit), int'(ehit));
            if (ehit) check(int'(hit_way) == eway, "R3", int'(hit_way), eway);
        end
        check(!(note_valid && !cand), "R5", int'(note_valid), int'(cand));
        if (note_valid && cand) check(note_addr == caddr, "R5", int'(note_addr), int'(caddr));
        if (cand) cands++;
        if (note_valid) notes++;

        // model update, same order as the requirements
        if (a && ehit) begin mr[as][eway] = 1; mp[as] = (eway + 1) % NW; end
        if (fl) begin
            for (int s = 0; s < NS; s++)
                for (int w = 0; w < NW; w++)
                    if (mv[s][w] && mf[s][w]) begin mv[s][w] = 0; mr[s][w] = 0; mf[s][w] = 0; end
        end
        if (f) begin
            mv[fs][vw] = 1; mt[fs][vw] = ft[4:0]; mr[fs][vw] = 0; mf[fs][vw] = fz;
            mp[fs] = (vw + 1) % NW;
        end
    endtask

    task automatic look(int s, int t, string lbl);
        step(1, mk(s, t, rnd() % 32), 0, '0, 0, 0, lbl);
    endtask

    task automatic fill(int s, int t, bit fz, string lbl);
        step(0, '0, 1, mk(s, t, rnd() % 32), fz, 0, lbl);
    endtask

    initial begin
        int n0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(!rsp_valid && !hit && !note_valid, "R1", int'({rsp_valid, hit, note_valid}), 0);
        for (int s = 0; s < NS; s++)
            for (int t = 0; t < 32; t++) look(s, t, "R1");

        // R3 placement and replacement
        for (int s = 0; s < NS; s++) begin
            fill(s, 3, s[0], "R3");
            fill(s, 9, 1'b1, "R3");
        end
        for (int s = 0; s < NS; s++) begin look(s, 3, "R3"); look(s, 9, "R3"); end
        for (int s = 0; s < NS; s++) fill(s, 17, 1'b0, "R3");
        for (int s = 0; s < NS; s++) begin look(s, 3, "R3"); look(s, 17, "R3"); look(s, 9, "R3"); end

        // R7 refill clears fuzzy
        fill(3, 9, 1'b0, "R7");
        // R8 flash
        step(0, '0, 0, '0, 0, 1, "R8");
        for (int s = 0; s < NS; s++) begin look(s, 9, "R8"); look(s, 17, "R8"); end

        // R9 fill and flash together
        fill(1, 22, 1'b1, "R9");
        step(0, '0, 1, mk(0, 12, 5), 1, 1, "R9");
        look(0, 12, "R9");
        look(1, 22, "R9");

        // R10 lookup during flash sees old state
        fill(2, 14, 1'b1, "R10");
        step(1, mk(2, 14, 7), 0, '0, 0, 1, "R10");
        look(2, 14, "R10");

        // R4 reused victims are never reported
        n0 = 0;
        for (int i = 0; i < 40; i++) begin
            int x, y, z, nb;
            x = (3 * i) % 32; y = (3 * i + 1) % 32; z = (3 * i + 2) % 32;
            fill(2, x, 1'b0, "R4");
            fill(2, y, 1'b0, "R4");
            look(2, x, "R4");
            look(2, y, "R4");
            nb = notes;
            fill(2, z, 1'b0, "R4");
            n0 += notes - nb;
        end
        check(n0 == 0, "R4", n0, 0);

        // R6 stream of unreused evictions
        for (int i = 0; i < 1200; i++) fill(i % 4, (i / 4) % 32, i[0], "R6");

        // mixed pseudo-random traffic
        for (int i = 0; i < 2500; i++) begin
            bit a, f, fz, fl;
            logic [AW-1:0] aa, fa;
            a  = (rnd() % 3) != 0;
            aa = mk(rnd() % 4, rnd() % 8, rnd() % 32);
            f  = (rnd() % 2) == 1;
            fa = mk(rnd() % 4, rnd() % 8, rnd() % 32);
            fz = (rnd() % 2) == 1;
            fl = (rnd() % 16) == 0;
            step(a, aa, f, fa, fz, fl, "R2");
        end

        check(cands >= 300, "R6", cands, 300);
        if (cands > 0) check((notes * 100 / cands) >= 18 && (notes * 100 / cands) <= 32,
                             "R6", notes * 100 / cands, 25);
        done = 1;
        summary();
        $finish;
    end

endmodule